// File: doc/BRIEF.md
# Monitor-Mode Read Sequencer

This block produces the byte stream a host receives when it reads a voltage-monitoring device in its monitoring mode. Each byte is requested over a simple request/valid handshake. A read transaction returns the 8-bit alarm-status word first. It then returns N stored fault snapshots, then N current conversion results. Each value is 16 bits wide and sent as two bytes. N is the number of active conversions, from 1 to `CH`.

The host can keep reading past the last current result. When it does, the stream wraps to the first current result, not to the status byte. A stop/NACK indication ends the transaction, and the next transaction starts again at the status byte. The current-result registers do not change while a read is in progress. A conversion that completes during a read is held in a per-channel pending slot, and a later conversion for the same channel replaces it. The held value is written into the current-result register in the first cycle after the read ends.

Top module: `monReadSeq`

## Requirements
- R1: After reset, `byteValid` and `byteData` are 0, and every current-result register reads back as 0.
- R2: The first byte of every read transaction is the value of `alarmStatus` in the cycle in which that byte was requested.
- R3: Each 16-bit value is sent high byte first. It carries the `DW`-bit result right-aligned, and the upper 16-`DW` bits are zero.
- R4: Bytes 1 to 2N carry the fault snapshots of channels 0 to N-1 in channel order. Bytes 2N+1 to 4N carry the current results of channels 0 to N-1 in the same order.
- R5: The byte requested after byte 4N is byte 2N+1, the high byte of current result 0. This wrap repeats for as long as the host keeps reading.
- R6: `byteValid` is high exactly in the cycle after a cycle with `byteReq` high and `txnEnd` low, and is low otherwise.
- R7: A `txnEnd` pulse ends the transaction, and the next requested byte is the status byte.
- R8: A conversion that arrives (`convValid`) during a read transaction does not change the current results returned by that transaction.
- R9: A conversion held during a read is written into its channel's current-result register once the read ends. If several conversions for the same channel are held, the most recent one is kept.
- R10: A conversion that arrives while no read is in progress is returned by the next read of that channel.
- R11: N = `numSel` + 1, where `numSel` is the number of active channels minus one.
- R12: If `byteReq` and `txnEnd` are high in the same cycle, no byte is sent and the transaction ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| numSel | input | $clog2(CH) | Number of active conversions minus one |
| alarmStatus | input | 8 | Alarm-status word, sent as byte 0 |
| faultVals | input | CH x DW | Stored fault snapshot for each channel |
| convValid | input | 1 | A new conversion result is presented |
| convChan | input | $clog2(CH) | Channel of the new conversion |
| convData | input | DW | Value of the new conversion |
| byteReq | input | 1 | Request for the next byte of the read |
| txnEnd | input | 1 | Stop or NACK: ends the read transaction |
| byteValid | output | 1 | `byteData` holds the requested byte |
| byteData | output | 8 | Byte returned to the host |

## Verification
The bench uses the default parameters, `CH` = 4 and `DW` = 12. With these values every setting of `numSel` from one to four active channels can be reached. With 12-bit results, the four zero bits at the top of each high byte (R3) are visible. Reads run past 4N so that the wrap to current result 0 is exercised for several values of N. A conversion that arrives during a read is checked against the frozen value in that read and against the committed value in the next read.

// File: rtl/monReadPkg.sv
package monReadPkg;

  localparam int CHAN_FIELD_W = 4;

  typedef enum logic [1:0] {
    SEC_STATUS = 2'd0,
    SEC_FAULT  = 2'd1,
    SEC_CUR    = 2'd2
  } secT;

  // strobes from the control to the datapath
  typedef struct packed {
    logic                    emit;
    secT                     sect;
    logic [CHAN_FIELD_W-1:0] chan;
    logic                    hiByte;
    logic                    freeze;
  } strbT;

endpackage

// File: rtl/monReadCtrl.sv
module monReadCtrl
  import monReadPkg::*;
#(
  parameter int CH = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        byteReq,
  input  logic                        txnEnd,
  input  logic [$clog2(CH)-1:0]       numSel,
  output strbT                        strb,
  output logic [$clog2(4*CH+1)-1:0]   rdPtr
);
  localparam int PW = $clog2(4*CH+1);

  logic          active;
  logic [PW-1:0] ptr, nVal, twoN, lastIdx, nextPtr, off;

  always_comb begin
    nVal    = PW'(numSel) + PW'(1);
    twoN    = nVal << 1;
    lastIdx = twoN << 1;
    // past the last current result: back to current result 0
    nextPtr = (ptr >= lastIdx) ? twoN + PW'(1) : ptr + PW'(1);

    strb = '0;
    if (ptr == '0) begin
      strb.sect = SEC_STATUS;
      off       = '0;
    end else if (ptr <= twoN) begin
      strb.sect = SEC_FAULT;
      off       = ptr - PW'(1);
    end else begin
      strb.sect = SEC_CUR;
      off       = ptr - twoN - PW'(1);
    end
    strb.chan   = CHAN_FIELD_W'(off >> 1);
    strb.hiByte = (ptr != '0) && !off[0];
    strb.emit   = byteReq && !txnEnd;
    strb.freeze = (active || byteReq) && !txnEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      ptr    <= '0;
    end else if (txnEnd) begin
      active <= 1'b0;
      ptr    <= '0;
    end else if (byteReq) begin
      active <= 1'b1;
      ptr    <= nextPtr;
    end
  end

  assign rdPtr = ptr;

endmodule

// File: rtl/monReadPath.sv
module monReadPath
  import monReadPkg::*;
#(
  parameter int CH = 4,
  parameter int DW = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strbT                       strb,
  input  logic [7:0]                 alarmStatus,
  input  logic [CH-1:0][DW-1:0]      faultVals,
  input  logic                       convValid,
  input  logic [$clog2(CH)-1:0]      convChan,
  input  logic [DW-1:0]              convData,
  output logic                       byteValid,
  output logic [7:0]                 byteData
);
  localparam int CW = $clog2(CH);

  logic [DW-1:0] curReg   [CH];
  logic [DW-1:0] pendData [CH];
  logic          pendValid[CH];

  for (genvar g = 0; g < CH; g++) begin : gChan
    logic hit;
    assign hit = convValid && (convChan == CW'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        curReg[g]    <= '0;
        pendData[g]  <= '0;
        pendValid[g] <= 1'b0;
      end else if (strb.freeze) begin
        // read in progress: hold the newest result for later
        if (hit) begin
          pendData[g]  <= convData;
          pendValid[g] <= 1'b1;
        end
      end else begin
        if (hit)               curReg[g] <= convData;
        else if (pendValid[g]) curReg[g] <= pendData[g];
        pendValid[g] <= 1'b0;
      end
    end
  end

  logic [CW-1:0] chIdx;
  logic [15:0]   word;
  logic [7:0]    selByte;

  always_comb begin
    chIdx = strb.chan[CW-1:0];
    if (strb.sect == SEC_FAULT) word = 16'(faultVals[chIdx]);
    else                        word = 16'(curReg[chIdx]);
    if (strb.sect == SEC_STATUS) selByte = alarmStatus;
    else if (strb.hiByte)        selByte = word[15:8];
    else                         selByte = word[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteValid <= 1'b0;
      byteData  <= '0;
    end else begin
      byteValid <= strb.emit;
      if (strb.emit) byteData <= selByte;
    end
  end

endmodule

// File: rtl/monReadSeq.sv
module monReadSeq
  import monReadPkg::*;
#(
  parameter int CH = 4,
  parameter int DW = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [$clog2(CH)-1:0]  numSel,
  input  logic [7:0]             alarmStatus,
  input  logic [CH-1:0][DW-1:0]  faultVals,
  input  logic                   convValid,
  input  logic [$clog2(CH)-1:0]  convChan,
  input  logic [DW-1:0]          convData,
  input  logic                   byteReq,
  input  logic                   txnEnd,
  output logic                   byteValid,
  output logic [7:0]             byteData
);
  localparam int PW = $clog2(4*CH+1);

  strbT          strb;
  logic [PW-1:0] rdPtr;

  monReadCtrl #(.CH(CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .byteReq(byteReq), .txnEnd(txnEnd),
    .numSel(numSel), .strb(strb), .rdPtr(rdPtr)
  );

  monReadPath #(.CH(CH), .DW(DW)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .alarmStatus(alarmStatus),
    .faultVals(faultVals), .convValid(convValid), .convChan(convChan),
    .convData(convData), .byteValid(byteValid), .byteData(byteData)
  );

endmodule

// File: rtl/monReadSeqChk.sv
module monReadSeqChk #(
  parameter int CH = 4,
  parameter int DW = 12
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        byteReq,
  input logic                        txnEnd,
  input logic                        byteValid,
  input logic [7:0]                  byteData,
  input logic [7:0]                  alarmStatus,
  input logic [$clog2(4*CH+1)-1:0]   rdPtr,
  input logic                        hiByte
);
  a_r6_valid_after_req: assert property (@(posedge clk) disable iff (!rstN)
    (byteReq && !txnEnd) |=> byteValid);

  a_r12_no_byte_without_req: assert property (@(posedge clk) disable iff (!rstN)
    (!byteReq || txnEnd) |=> !byteValid);

  a_r7_end_restarts: assert property (@(posedge clk) disable iff (!rstN)
    txnEnd |=> (rdPtr == '0));

  a_r2_status_first: assert property (@(posedge clk) disable iff (!rstN)
    (byteReq && !txnEnd && rdPtr == '0) |=> (byteData == $past(alarmStatus)));

  a_r3_high_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    (byteReq && !txnEnd && hiByte) |=> (byteData[7:DW-8] == '0));
endmodule

bind monReadSeq monReadSeqChk #(.CH(CH), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .byteReq(byteReq), .txnEnd(txnEnd),
  .byteValid(byteValid), .byteData(byteData), .alarmStatus(alarmStatus),
  .rdPtr(rdPtr), .hiByte(strb.hiByte)
);

// File: tb/tb_monReadSeq.sv
module tb_monReadSeq;
  localparam int CH = 4;
  localparam int DW = 12;
  localparam int NV = 4;
  localparam int TBL_SEL[NV] = '{3, 1, 2, 0};
  localparam int TBL_LEN[NV] = '{20, 11, 15, 7};

  logic clk = 0, rstN = 0;
  logic [1:0] numSel = 0;
  logic [7:0] alarmStatus = 8'h00;
  logic [CH-1:0][DW-1:0] faultVals;
  logic convValid = 0;
  logic [1:0] convChan = 0;
  logic [DW-1:0] convData = 0;
  logic byteReq = 0, txnEnd = 0;
  logic byteValid;
  logic [7:0] byteData;

  logic [DW-1:0] expCur[CH];
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  monReadSeq #(.CH(CH), .DW(DW)) dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(int n, int k);
    int twoN = 2 * n;
    int off;
    logic [15:0] w;
    if (k == 0) return alarmStatus;
    if (k <= twoN) begin
      off = k - 1;
      w = 16'(faultVals[off/2]);
    end else begin
      off = (k - twoN - 1) % twoN;
      w = 16'(expCur[off/2]);
    end
    return (off % 2 == 0) ? w[15:8] : w[7:0];
  endfunction

  function automatic string tagOf(int n, int k);
    if (k == 0) return "R2";
    if (k <= 2 * n) return "R3/R11";
    if (k <= 4 * n) return "R4";
    return "R5";
  endfunction

  task automatic readByte(output logic v, output logic [7:0] d);
    @(negedge clk) byteReq = 1;
    @(negedge clk) byteReq = 0;
    v = byteValid;
    d = byteData;
  endtask

  task automatic endTxn();
    @(negedge clk) txnEnd = 1;
    @(negedge clk) txnEnd = 0;
  endtask

  task automatic conv(int ch, logic [DW-1:0] val);
    @(negedge clk) begin convValid = 1; convChan = 2'(ch); convData = val; end
    @(negedge clk) convValid = 0;
  endtask

  task automatic readCheck(int n, int len);
    logic v;
    logic [7:0] d;
    for (int k = 0; k < len; k++) begin
      readByte(v, d);
      chk("R6", {7'b0, v}, 8'h01);
      chk(tagOf(n, k), d, model(n, k));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic v;
    logic [7:0] d;
    faultVals[0] = 12'h9A1; faultVals[1] = 12'h0C3;
    faultVals[2] = 12'h7FE; faultVals[3] = 12'h456;
    for (int i = 0; i < CH; i++) expCur[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk("R1", {7'b0, byteValid}, 8'h00);
    chk("R1", byteData, 8'h00);
    // R1: current results read as zero
    numSel = 3; alarmStatus = 8'h5A;
    readCheck(4, 17);
    endTxn();

    // R10: conversions outside a read land at once
    conv(0, 12'h123); conv(1, 12'hABC); conv(2, 12'h0F0); conv(3, 12'hFFF);
    expCur[0] = 12'h123; expCur[1] = 12'hABC; expCur[2] = 12'h0F0; expCur[3] = 12'hFFF;

    // table walk: R2 R3 R4 R5 R11 for each N
    for (int t = 0; t < NV; t++) begin
      numSel = 2'(TBL_SEL[t]);
      alarmStatus = 8'(8'h30 + t);
      readCheck(TBL_SEL[t] + 1, TBL_LEN[t]);
      endTxn();
    end

    // R8 / R9: freeze during a read, latest held value commits
    numSel = 3; alarmStatus = 8'hC7;
    readByte(v, d);
    chk("R2", d, 8'hC7);
    conv(1, 12'h555);
    conv(1, 12'h666);
    for (int k = 1; k < 17; k++) begin
      readByte(v, d);
      chk((k > 8) ? "R8" : "R4", d, model(4, k));
    end
    endTxn();
    expCur[1] = 12'h666;
    @(negedge clk);
    readCheck(4, 17);   // bytes 11/12 show committed R9 value
    endTxn();

    // R10 again after a read
    conv(2, 12'h321); expCur[2] = 12'h321;
    readCheck(4, 17);
    endTxn();

    // R6: valid lasts one cycle only
    readByte(v, d);
    @(negedge clk);
    chk("R6", {7'b0, byteValid}, 8'h00);
    endTxn();

    // R12: request and end in the same cycle
    readByte(v, d);
    readByte(v, d);
    @(negedge clk) begin byteReq = 1; txnEnd = 1; end
    @(negedge clk) begin byteReq = 0; txnEnd = 0; end
    chk("R12", {7'b0, byteValid}, 8'h00);
    alarmStatus = 8'hE1;
    readByte(v, d);
    chk("R7", d, 8'hE1);
    endTxn();

    // R7: end mid-stream, new read restarts at status
    numSel = 1; alarmStatus = 8'h2B;
    readCheck(2, 5);
    endTxn();
    alarmStatus = 8'h2C;
    readByte(v, d);
    chk("R7", d, 8'h2C);
    readByte(v, d);
    chk("R7", d, model(2, 1));
    endTxn();

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule